// File: doc/BRIEF.md
# Streaming Complex Matrix Multiplier

This block multiplies two small complex matrices of fixed size, A with M rows and K columns and B with K rows and N columns. Both use signed fixed-point, and each element has a separate real bus and imaginary bus. The two operands arrive as independent element streams in row-major order. Each stream has its own valid and ready pair, so A and B can be delivered at different times and at different rates. A ready that is low in one cycle means the block will discard whatever is presented on that input in the next cycle, even when valid is high.

Once every element of both operands is held internally, the block runs complex multiply-accumulate over the inner dimension. Each operand can be conjugated first, chosen by a parameter. Each sum is kept at full precision. Its extra fraction bits are then dropped by truncation toward minus infinity, and the result is saturated into the output format. The product C streams out in row-major order. Each element carries a flag that is high when its real part, its imaginary part or both had to be clamped. The output valid is gated by the downstream ready, so it is never high while downstream refuses data.

The number of register stages between the multipliers and the accumulator is a parameter. It changes latency but never the results.

Top module: `cplx_matmul`

## Requirements
- R1: While reset is high and in the first cycle after it, outValid is low. From the first cycle after reset, aReady and bReady are high.
- R2: A beat on an input is taken only when its valid is high and its ready was high in the previous cycle. A beat presented when ready was low the cycle before is discarded and has no effect on any result.
- R3: The A and B streams are handled independently. B can be fully loaded while A has not started, and then bReady is low while aReady stays high. No computation starts until both operands are complete.
- R4: In any cycle where outReady is low, outValid is low.
- R5: Element (i,j) of C leaves as the (i·N+j)-th output beat. A element (i,k) is the (i·K+k)-th A beat, and B element (k,j) is the (k·N+j)-th B beat. Its real part is the sum over k of ar·br − ai·bi and its imaginary part is the sum of ar·bi + ai·br, both taken after the optional conjugation.
- R6: With conjugation of an operand enabled by parameter, the imaginary part of every element of that operand is negated before multiplication. With it disabled, the operand is used unchanged.
- R7: When the truncated real or imaginary sum exceeds the output range, that part is clamped to the most positive or most negative output code, and outOvf is high for that element. Otherwise outOvf is low.
- R8: From the moment an operand is complete until the last C element has been taken downstream, no further beat of that operand is accepted. After the last C element, both readies are high again in the next cycle.
- R9: Fraction bits beyond the output format are dropped by truncation toward minus infinity. For example, a sum of −2 at the input product scale gives −1 output LSB.
- R10: Changing the pipeline depth parameter changes only the latency, not the values or the order of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| aValid | input | 1 | A element present |
| aReady | output | 1 | A beat may be presented next cycle |
| aRe | input | IN_W | A element real part |
| aIm | input | IN_W | A element imaginary part |
| bValid | input | 1 | B element present |
| bReady | output | 1 | B beat may be presented next cycle |
| bRe | input | IN_W | B element real part |
| bIm | input | IN_W | B element imaginary part |
| outReady | input | 1 | Downstream can take a C element |
| outValid | output | 1 | C element present |
| outRe | output | OUT_W | C element real part |
| outIm | output | OUT_W | C element imaginary part |
| outOvf | output | 1 | C element was saturated |

## Verification
The bench holds back the last beat of an operand so that the block's ready drops for a cycle, and it presents garbage with valid high in exactly that cycle. A design that took the beat on the current ready instead of the previous one would swallow the garbage and shift every later product. One scenario loads B completely before A starts. A design that coupled the streams, or that began computing early, would deliver wrong products or stop accepting A. Other scenarios use operands at the corners of the input range, with A conjugated, to push sums past both rails, and use tiny negative sums. These catch a clamp that only works in one direction, a missing flag, and truncation toward zero. Downstream stalls check that outValid never rises while outReady is low and that no element is lost or repeated across a stall.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
  typedef enum logic [1:0] {PH_LOAD, PH_CALC, PH_DRAIN, PH_EMIT} cmmPhase_t;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic macVld;
    logic macFirst;
    logic macLast;
  } cmmStrb_t;
endpackage

// File: rtl/cmm_ctrl.sv
module cmm_ctrl import cmm_pkg::*; #(
  parameter int M = 2,
  parameter int K = 2,
  parameter int N = 2,
  parameter int PIPE = 2,
  localparam int ATOT = M * K,
  localparam int BTOT = K * N,
  localparam int CTOT = M * N,
  localparam int AIW = (ATOT > 1) ? $clog2(ATOT) : 1,
  localparam int BIW = (BTOT > 1) ? $clog2(BTOT) : 1,
  localparam int CIW = (CTOT > 1) ? $clog2(CTOT) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           aValid,
  output logic           aReady,
  input  logic           bValid,
  output logic           bReady,
  input  logic           outReady,
  output logic           outValid,
  output cmmStrb_t       strb,
  output logic [AIW-1:0] aWrIdx,
  output logic [BIW-1:0] bWrIdx,
  output logic [AIW-1:0] rdAIdx,
  output logic [BIW-1:0] rdBIdx,
  output logic [CIW-1:0] macIdx,
  output logic [CIW-1:0] emitIdx
);
  localparam int ACW = $clog2(ATOT + 1);
  localparam int BCW = $clog2(BTOT + 1);
  localparam int RW  = (M > 1) ? $clog2(M) : 1;
  localparam int CW  = (N > 1) ? $clog2(N) : 1;
  localparam int KW  = (K > 1) ? $clog2(K) : 1;
  localparam int DW  = (PIPE > 1) ? $clog2(PIPE) : 1;

  cmmPhase_t      phase;
  logic [ACW-1:0] cntA;
  logic [BCW-1:0] cntB;
  logic           permA, permB;
  logic [RW-1:0]  row;
  logic [CW-1:0]  col;
  logic [KW-1:0]  kk;
  logic [DW-1:0]  drainCnt;
  logic [CIW-1:0] emitCnt;
  logic           acceptA, acceptB, lastMac;

  // Ready assumes a beat may land this cycle, so the grant for the next cycle never overfills.
  assign aReady  = (phase == PH_LOAD) && (int'(cntA) + int'(permA) < ATOT);
  assign bReady  = (phase == PH_LOAD) && (int'(cntB) + int'(permB) < BTOT);
  assign acceptA = aValid && permA;
  assign acceptB = bValid && permB;

  assign strb.wrA      = acceptA;
  assign strb.wrB      = acceptB;
  assign strb.macVld   = (phase == PH_CALC);
  assign strb.macFirst = (kk == '0);
  assign strb.macLast  = (int'(kk) == K - 1);
  assign lastMac = strb.macLast && (int'(row) == M - 1) && (int'(col) == N - 1);

  assign aWrIdx  = AIW'(cntA);
  assign bWrIdx  = BIW'(cntB);
  assign rdAIdx  = AIW'(int'(row) * K + int'(kk));
  assign rdBIdx  = BIW'(int'(kk) * N + int'(col));
  assign macIdx  = CIW'(int'(row) * N + int'(col));
  assign emitIdx = emitCnt;
  assign outValid = (phase == PH_EMIT) && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_LOAD;
      cntA     <= '0;
      cntB     <= '0;
      permA    <= 1'b0;
      permB    <= 1'b0;
      row      <= '0;
      col      <= '0;
      kk       <= '0;
      drainCnt <= '0;
      emitCnt  <= '0;
    end else begin
      permA <= aReady;
      permB <= bReady;
      if (acceptA) cntA <= cntA + 1'b1;
      if (acceptB) cntB <= cntB + 1'b1;
      case (phase)
        PH_LOAD: if (int'(cntA) == ATOT && int'(cntB) == BTOT) phase <= PH_CALC;
        PH_CALC: begin
          if (strb.macLast) begin
            kk <= '0;
            if (int'(col) == N - 1) begin
              col <= '0;
              row <= row + 1'b1;
            end else begin
              col <= col + 1'b1;
            end
          end else begin
            kk <= kk + 1'b1;
          end
          if (lastMac) begin
            phase    <= PH_DRAIN;
            row      <= '0;
            drainCnt <= '0;
          end
        end
        PH_DRAIN: begin
          if (int'(drainCnt) == PIPE - 1) phase <= PH_EMIT;
          else drainCnt <= drainCnt + 1'b1;
        end
        default: begin
          if (outValid) begin
            if (int'(emitCnt) == CTOT - 1) begin
              phase   <= PH_LOAD;
              emitCnt <= '0;
              cntA    <= '0;
              cntB    <= '0;
            end else begin
              emitCnt <= emitCnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R2
  accept_a_chk: assert property (@(posedge clk) disable iff (rst) strb.wrA |-> $past(aReady));
  // R2
  accept_b_chk: assert property (@(posedge clk) disable iff (rst) strb.wrB |-> $past(bReady));
  // R3
  full_chk: assert property (@(posedge clk) disable iff (rst)
    strb.macVld |-> (int'(cntA) == ATOT && int'(cntB) == BTOT));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(cntA) == ATOT) |-> !strb.wrA);
  // R4
  out_gate_chk: assert property (@(posedge clk) disable iff (rst) !outReady |-> !outValid);
endmodule

// File: rtl/cmm_dpath.sv
module cmm_dpath import cmm_pkg::*; #(
  parameter int M = 2,
  parameter int K = 2,
  parameter int N = 2,
  parameter int IN_W = 16,
  parameter int IN_FRAC = 14,
  parameter int OUT_W = 20,
  parameter int OUT_FRAC = 14,
  parameter bit CONJ_A = 1'b0,
  parameter bit CONJ_B = 1'b0,
  parameter int PIPE = 2,
  localparam int ATOT = M * K,
  localparam int BTOT = K * N,
  localparam int CTOT = M * N,
  localparam int AIW = (ATOT > 1) ? $clog2(ATOT) : 1,
  localparam int BIW = (BTOT > 1) ? $clog2(BTOT) : 1,
  localparam int CIW = (CTOT > 1) ? $clog2(CTOT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cmmStrb_t                strb,
  input  logic [AIW-1:0]          aWrIdx,
  input  logic [BIW-1:0]          bWrIdx,
  input  logic signed [IN_W-1:0]  aRe,
  input  logic signed [IN_W-1:0]  aIm,
  input  logic signed [IN_W-1:0]  bRe,
  input  logic signed [IN_W-1:0]  bIm,
  input  logic [AIW-1:0]          rdAIdx,
  input  logic [BIW-1:0]          rdBIdx,
  input  logic [CIW-1:0]          macIdx,
  input  logic [CIW-1:0]          emitIdx,
  output logic signed [OUT_W-1:0] outRe,
  output logic signed [OUT_W-1:0] outIm,
  output logic                    outOvf
);
  localparam int EW    = IN_W + 1;
  localparam int PW    = 2 * EW;
  localparam int SW    = PW + 1;
  localparam int ACC_W = SW + ((K > 1) ? $clog2(K) : 0);
  localparam int SH    = 2 * IN_FRAC - OUT_FRAC;
  localparam longint OMAXL = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] OMAX = ACC_W'(OMAXL);
  localparam logic signed [ACC_W-1:0] OMIN = ACC_W'(-OMAXL - 1);

  logic signed [IN_W-1:0]  aReBuf [ATOT];
  logic signed [IN_W-1:0]  aImBuf [ATOT];
  logic signed [IN_W-1:0]  bReBuf [BTOT];
  logic signed [IN_W-1:0]  bImBuf [BTOT];
  logic signed [OUT_W-1:0] cReBuf [CTOT];
  logic signed [OUT_W-1:0] cImBuf [CTOT];
  logic [CTOT-1:0]         cOvfBuf;

  logic signed [EW-1:0] opARe, xaIm, opAIm, opBRe, xbIm, opBIm;
  logic signed [PW-1:0] mRR, mII, mRI, mIR;
  logic signed [SW-1:0] prodRe, prodIm;

  assign opARe = {aReBuf[rdAIdx][IN_W-1], aReBuf[rdAIdx]};
  assign xaIm  = {aImBuf[rdAIdx][IN_W-1], aImBuf[rdAIdx]};
  assign opBRe = {bReBuf[rdBIdx][IN_W-1], bReBuf[rdBIdx]};
  assign xbIm  = {bImBuf[rdBIdx][IN_W-1], bImBuf[rdBIdx]};

  generate
    if (CONJ_A) begin : g_conjA
      assign opAIm = -xaIm;
    end else begin : g_plainA
      assign opAIm = xaIm;
    end
    if (CONJ_B) begin : g_conjB
      assign opBIm = -xbIm;
    end else begin : g_plainB
      assign opBIm = xbIm;
    end
  endgenerate

  assign mRR = opARe * opBRe;
  assign mII = opAIm * opBIm;
  assign mRI = opARe * opBIm;
  assign mIR = opAIm * opBRe;
  assign prodRe = SW'(mRR) - SW'(mII);
  assign prodIm = SW'(mRI) + SW'(mIR);

  logic signed [SW-1:0] pRe [PIPE];
  logic signed [SW-1:0] pIm [PIPE];
  logic [CIW-1:0]       pIdx [PIPE];
  logic [PIPE-1:0]      pVld, pFirst, pLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      pVld   <= '0;
      pFirst <= '0;
      pLast  <= '0;
      for (int s = 0; s < PIPE; s++) begin
        pRe[s]  <= '0;
        pIm[s]  <= '0;
        pIdx[s] <= '0;
      end
    end else begin
      pVld[0]   <= strb.macVld;
      pFirst[0] <= strb.macFirst;
      pLast[0]  <= strb.macLast;
      pRe[0]    <= prodRe;
      pIm[0]    <= prodIm;
      pIdx[0]   <= macIdx;
      for (int s = 1; s < PIPE; s++) begin
        pVld[s]   <= pVld[s-1];
        pFirst[s] <= pFirst[s-1];
        pLast[s]  <= pLast[s-1];
        pRe[s]    <= pRe[s-1];
        pIm[s]    <= pIm[s-1];
        pIdx[s]   <= pIdx[s-1];
      end
    end
  end

  logic signed [ACC_W-1:0] accRe, accIm, sumRe, sumIm, shRe, shIm;
  logic signed [OUT_W-1:0] satRe, satIm;
  logic                    clipRe, clipIm, wrC;

  assign wrC = pVld[PIPE-1] && pLast[PIPE-1];

  always_comb begin
    sumRe = pFirst[PIPE-1] ? ACC_W'(pRe[PIPE-1]) : accRe + ACC_W'(pRe[PIPE-1]);
    sumIm = pFirst[PIPE-1] ? ACC_W'(pIm[PIPE-1]) : accIm + ACC_W'(pIm[PIPE-1]);
    shRe  = sumRe >>> SH;
    shIm  = sumIm >>> SH;
    clipRe = (shRe > OMAX) || (shRe < OMIN);
    clipIm = (shIm > OMAX) || (shIm < OMIN);
    satRe = (shRe > OMAX) ? OMAX[OUT_W-1:0] : (shRe < OMIN) ? OMIN[OUT_W-1:0] : shRe[OUT_W-1:0];
    satIm = (shIm > OMAX) ? OMAX[OUT_W-1:0] : (shIm < OMIN) ? OMIN[OUT_W-1:0] : shIm[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accRe   <= '0;
      accIm   <= '0;
      cOvfBuf <= '0;
      for (int i = 0; i < ATOT; i++) begin
        aReBuf[i] <= '0;
        aImBuf[i] <= '0;
      end
      for (int i = 0; i < BTOT; i++) begin
        bReBuf[i] <= '0;
        bImBuf[i] <= '0;
      end
      for (int i = 0; i < CTOT; i++) begin
        cReBuf[i] <= '0;
        cImBuf[i] <= '0;
      end
    end else begin
      if (strb.wrA) begin
        aReBuf[aWrIdx] <= aRe;
        aImBuf[aWrIdx] <= aIm;
      end
      if (strb.wrB) begin
        bReBuf[bWrIdx] <= bRe;
        bImBuf[bWrIdx] <= bIm;
      end
      if (pVld[PIPE-1]) begin
        accRe <= sumRe;
        accIm <= sumIm;
      end
      if (wrC) begin
        cReBuf[pIdx[PIPE-1]]  <= satRe;
        cImBuf[pIdx[PIPE-1]]  <= satIm;
        cOvfBuf[pIdx[PIPE-1]] <= clipRe || clipIm;
      end
    end
  end

  assign outRe  = cReBuf[emitIdx];
  assign outIm  = cImBuf[emitIdx];
  assign outOvf = cOvfBuf[emitIdx];

  // R7
  ovf_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (wrC && (clipRe || clipIm)) |=>
      (cOvfBuf[$past(pIdx[PIPE-1])] &&
       (cReBuf[$past(pIdx[PIPE-1])] == OMAX[OUT_W-1:0] || cReBuf[$past(pIdx[PIPE-1])] == OMIN[OUT_W-1:0] ||
        cImBuf[$past(pIdx[PIPE-1])] == OMAX[OUT_W-1:0] || cImBuf[$past(pIdx[PIPE-1])] == OMIN[OUT_W-1:0])));
  // R5
  first_chk: assert property (@(posedge clk) disable iff (rst)
    (pVld[PIPE-1] && pFirst[PIPE-1]) |-> ($past(pVld[PIPE-1]) -> $past(pLast[PIPE-1])));
endmodule

// File: rtl/cplx_matmul.sv
module cplx_matmul import cmm_pkg::*; #(
  parameter int M = 2,
  parameter int K = 2,
  parameter int N = 2,
  parameter int IN_W = 16,
  parameter int IN_FRAC = 14,
  parameter int OUT_W = 20,
  parameter int OUT_FRAC = 14,
  parameter bit CONJ_A = 1'b0,
  parameter bit CONJ_B = 1'b0,
  parameter int PIPE = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    aValid,
  output logic                    aReady,
  input  logic signed [IN_W-1:0]  aRe,
  input  logic signed [IN_W-1:0]  aIm,
  input  logic                    bValid,
  output logic                    bReady,
  input  logic signed [IN_W-1:0]  bRe,
  input  logic signed [IN_W-1:0]  bIm,
  input  logic                    outReady,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outRe,
  output logic signed [OUT_W-1:0] outIm,
  output logic                    outOvf
);
  localparam int ATOT = M * K;
  localparam int BTOT = K * N;
  localparam int CTOT = M * N;
  localparam int AIW = (ATOT > 1) ? $clog2(ATOT) : 1;
  localparam int BIW = (BTOT > 1) ? $clog2(BTOT) : 1;
  localparam int CIW = (CTOT > 1) ? $clog2(CTOT) : 1;

  cmmStrb_t       strb;
  logic [AIW-1:0] aWrIdx, rdAIdx;
  logic [BIW-1:0] bWrIdx, rdBIdx;
  logic [CIW-1:0] macIdx, emitIdx;

  cmm_ctrl #(.M(M), .K(K), .N(N), .PIPE(PIPE)) u_ctrl (
    .clk(clk), .rst(rst),
    .aValid(aValid), .aReady(aReady),
    .bValid(bValid), .bReady(bReady),
    .outReady(outReady), .outValid(outValid),
    .strb(strb), .aWrIdx(aWrIdx), .bWrIdx(bWrIdx),
    .rdAIdx(rdAIdx), .rdBIdx(rdBIdx), .macIdx(macIdx), .emitIdx(emitIdx)
  );

  cmm_dpath #(
    .M(M), .K(K), .N(N), .IN_W(IN_W), .IN_FRAC(IN_FRAC),
    .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .CONJ_A(CONJ_A), .CONJ_B(CONJ_B), .PIPE(PIPE)
  ) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .aWrIdx(aWrIdx), .bWrIdx(bWrIdx),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .rdAIdx(rdAIdx), .rdBIdx(rdBIdx), .macIdx(macIdx), .emitIdx(emitIdx),
    .outRe(outRe), .outIm(outIm), .outOvf(outOvf)
  );
endmodule

// File: tb/test_cplx_matmul.sv
`timescale 1ns/1ps
module test_cplx_matmul;
  localparam int DIM = 2;
  localparam int NE = DIM * DIM;
  localparam int OW = 18;
  localparam int SH = 14;
  localparam bit CA = 1'b1;
  localparam bit CB = 1'b0;
  localparam longint OMAX = (longint'(1) <<< (OW - 1)) - 1;
  localparam longint OMIN = -OMAX - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aValid = 1'b0, bValid = 1'b0, outReady = 1'b1;
  logic signed [15:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0;
  logic aReady, bReady, outValid, outOvf;
  logic signed [OW-1:0] outRe, outIm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic signed [15:0] aReV [NE], aImV [NE], bReV [NE], bImV [NE];
  longint eRe [NE], eIm [NE];
  bit eOv [NE];

  always #2.5 clk = ~clk;

  cplx_matmul #(.OUT_W(OW), .CONJ_A(CA), .CONJ_B(CB), .PIPE(3)) i_cplx_matmul (
    .clk(clk), .rst(rst),
    .aValid(aValid), .aReady(aReady), .aRe(aRe), .aIm(aIm),
    .bValid(bValid), .bReady(bReady), .bRe(bRe), .bIm(bIm),
    .outReady(outReady), .outValid(outValid),
    .outRe(outRe), .outIm(outIm), .outOvf(outOvf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model();
    for (int i = 0; i < DIM; i++) begin
      for (int j = 0; j < DIM; j++) begin
        longint sr = 0, si = 0;
        for (int k = 0; k < DIM; k++) begin
          longint ar = longint'(aReV[i*DIM+k]);
          longint ai = CA ? -longint'(aImV[i*DIM+k]) : longint'(aImV[i*DIM+k]);
          longint br = longint'(bReV[k*DIM+j]);
          longint bi = CB ? -longint'(bImV[k*DIM+j]) : longint'(bImV[k*DIM+j]);
          sr += ar * br - ai * bi;
          si += ar * bi + ai * br;
        end
        sr = sr >>> SH;
        si = si >>> SH;
        eOv[i*DIM+j] = (sr > OMAX) || (sr < OMIN) || (si > OMAX) || (si < OMIN);
        eRe[i*DIM+j] = (sr > OMAX) ? OMAX : (sr < OMIN) ? OMIN : sr;
        eIm[i*DIM+j] = (si > OMAX) ? OMAX : (si < OMIN) ? OMIN : si;
      end
    end
  endtask

  task automatic feed_a(input int gapAt);
    int idx = 0;
    bit rp;
    bit gapped = 1'b0;
    @(negedge clk);
    aValid = 1'b0;
    rp = aReady;
    while (idx < NE) begin
      @(negedge clk);
      if (!rp) begin
        aValid = 1'b1; aRe = 16'sh7fff; aIm = 16'sh7fff;   // R2 must be dropped
      end else if (idx == gapAt && !gapped) begin
        aValid = 1'b0; gapped = 1'b1;
      end else begin
        aValid = 1'b1; aRe = aReV[idx]; aIm = aImV[idx]; idx++;
      end
      rp = aReady;
    end
    @(negedge clk);
    aValid = 1'b1; aRe = 16'sh7fff; aIm = 16'sh7fff;         // R8 must be ignored
  endtask

  task automatic feed_b(input int gapAt);
    int idx = 0;
    bit rp;
    bit gapped = 1'b0;
    @(negedge clk);
    bValid = 1'b0;
    rp = bReady;
    while (idx < NE) begin
      @(negedge clk);
      if (!rp) begin
        bValid = 1'b1; bRe = 16'sh7fff; bIm = 16'sh7fff;
      end else if (idx == gapAt && !gapped) begin
        bValid = 1'b0; gapped = 1'b1;
      end else begin
        bValid = 1'b1; bRe = bReV[idx]; bIm = bImV[idx]; idx++;
      end
      rp = bReady;
    end
    @(negedge clk);
    bValid = 1'b1; bRe = 16'sh7fff; bIm = 16'sh7fff;
  endtask

  task automatic collect(input int stallMod, input string req);
    int idx = 0;
    int cyc = 0;
    bit first = 1'b1;
    while (idx < NE) begin
      @(negedge clk);
      outReady = !(stallMod > 0 && (cyc % stallMod) == 0);
      cyc++;
      #1;
      if (first) begin
        check(!aReady && !bReady, "R8", "readies low while busy", {aReady, bReady}, 0);
        first = 1'b0;
      end
      if (!outReady) check(!outValid, "R4", "valid while stalled", outValid, 0);
      if (outValid && outReady) begin
        check(outRe == eRe[idx] && outIm == eIm[idx] && outOvf == eOv[idx], req,
              $sformatf("element %0d re/im/ovf %0d/%0d/%0d exp", idx, outRe, outIm, outOvf),
              longint'(outRe), eRe[idx]);
        if (outRe == eRe[idx] && (outIm != eIm[idx] || outOvf != eOv[idx]))
          $display("  element %0d im %0d exp %0d, ovf %0d exp %0d", idx, outIm, eIm[idx], outOvf, eOv[idx]);
        idx++;
      end
    end
    aValid = 1'b0;
    bValid = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    check(aReady && bReady, "R8", "readies back after last C", {aReady, bReady}, 3);
  endtask

  task automatic run(input int gapA, input int gapB, input int stallMod,
                     input bit bFirst, input string req);
    model();
    if (bFirst) begin
      feed_b(-1);
      repeat (3) @(negedge clk);
      check(aReady && !bReady, "R3", "A open, B closed", {aReady, bReady}, 2);
      feed_a(gapA);
    end else begin
      fork
        feed_a(gapA);
        feed_b(gapB);
      join
    end
    collect(stallMod, req);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid, "R1", "outValid in reset", outValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid, "R1", "outValid after reset", outValid, 0);
    check(aReady && bReady, "R1", "readies after reset", {aReady, bReady}, 3);
  endtask

  task automatic test_basic();
    for (int i = 0; i < NE; i++) begin
      aReVi: begin end
      aReV[i] = 16'(i * 9137 - 14000);
      aImV[i] = 16'(7000 - i * 5311);
      bReV[i] = 16'(i * 4421 + 3001);
      bImV[i] = 16'(-9000 + i * 6007);
    end
    run(-1, -1, 0, 1'b0, "R5 R6 R10");
  endtask

  task automatic test_stalls();
    for (int i = 0; i < NE; i++) begin
      aReV[i] = 16'(-20000 + i * 11111);
      aImV[i] = 16'(13000 - i * 3333);
      bReV[i] = 16'(15000 - i * 7777);
      bImV[i] = 16'(i * 8888 - 12000);
    end
    run(NE - 1, NE - 1, 2, 1'b0, "R2 R4");
  endtask

  task automatic test_b_first();
    for (int i = 0; i < NE; i++) begin
      aReV[i] = 16'(5000 + i * 1234);
      aImV[i] = 16'(-3000 - i * 2345);
      bReV[i] = 16'(-7000 + i * 3456);
      bImV[i] = 16'(2000 + i * 4567);
    end
    run(-1, -1, 3, 1'b1, "R3");
  endtask

  task automatic test_overflow();
    for (int i = 0; i < NE; i++) begin
      aReV[i] = 16'sh8000;
      aImV[i] = 16'sh8000;
      bReV[i] = (i % 2 == 0) ? 16'sh8000 : 16'sh7fff;
      bImV[i] = (i % 2 == 0) ? 16'sh8000 : 16'sh7fff;
    end
    run(-1, -1, 0, 1'b0, "R7");
    check(eOv[0] && eRe[0] == OMAX && eOv[1] && eRe[1] == OMIN, "R7", "model rails",
          eRe[1], OMIN);
  endtask

  task automatic test_trunc();
    for (int i = 0; i < NE; i++) begin
      aReV[i] = 16'sd1;
      aImV[i] = '0;
      bReV[i] = -16'sd1;
      bImV[i] = '0;
    end
    run(-1, -1, 0, 1'b0, "R9");
    check(eRe[0] == -1, "R9", "floor of -2 LSB", eRe[0], -1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_basic();
    test_stalls();
    test_b_first();
    test_overflow();
    test_trunc();
    test_basic();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule